// File: doc/BRIEF.md
# Transfer FIFO with DMA Request Control

This block is the data staging buffer between a parallel peripheral bus engine and a host that moves bytes either through a DMA channel or through programmed I/O. It holds up to eight bytes. The transfer direction decides who fills it and who drains it. In the inbound direction the bus engine pushes received bytes and the host pops them. In the outbound direction the host's DMA writes push bytes and the bus engine pops them for sending.

A small state machine drives the DMA request line (`dreq`) from FIFO occupancy, direction, mode and whether the remaining transfer count is nonzero. It has three states:
- `DQ_OFF`: request low.
- `DQ_SEND`: outbound request high.
- `DQ_RECV`: inbound request high.

The transitions are:
- START_SEND: a transfer start in DMA mode, outbound, with a nonzero count and a FIFO that is not full, goes to `DQ_SEND`.
- START_OFF: any other transfer start goes to `DQ_OFF`. This includes every start in programmed-I/O mode.
- RECV_ARRIVE: a byte accepted from the bus in inbound DMA mode moves `DQ_OFF` to `DQ_RECV`.
- SEND_FILLED: a push that fills the FIFO moves `DQ_SEND` to `DQ_OFF`.
- RECV_DRAINED: a host DMA read that empties the FIFO moves `DQ_RECV` to `DQ_OFF`.

A transfer start takes priority over every other transition.

Every host pop loads a data register. The data register is the host's read value for both the DMA and the programmed-I/O paths. When a host read finds the FIFO empty, the register keeps its last value.

Top module: `dma_xfer_fifo`

## Requirements
- R1: After reset `fifo_empty`=1, `fifo_full`=0, `dreq`=0 and `host_rdata`=0x00.
- R2: The FIFO holds 8 bytes and delivers them in push order. `fifo_full` and `fifo_empty` are registered and reflect the occupancy in the cycle after an accepted push or pop.
- R3: A push while `fifo_full`=1 is discarded. Occupancy and the stored bytes are unchanged.
- R4: A host read (`host_dma_rd` or `host_pio_rd`) while the FIFO is empty pops nothing. `host_rdata` keeps its last value.
- R5: An accepted push and an accepted pop in the same cycle both take effect, and the occupancy is unchanged.
- R6: On `xfer_start` with `dma_mode`=1, `dir_in`=0 (outbound), `tc_nonzero`=1 and the FIFO not full, `dreq` is 1 from the next cycle. A start with `tc_nonzero`=0 leaves `dreq`=0.
- R7: Outbound, `dreq` falls in the cycle after the host DMA write that fills the FIFO.
- R8: Inbound (`dir_in`=1) with `dma_mode`=1, each byte accepted from `bus_push` makes `dreq` 1 from the next cycle. A start in that direction alone does not raise it.
- R9: Inbound, `dreq` falls in the cycle after a host DMA read that leaves the FIFO empty. It stays 1 while bytes remain.
- R10: `xfer_start` with `dma_mode`=0 forces `dreq` to 0 from the next cycle.
- R11: The direction selects the FIFO's ends:
  - When `dir_in`=1, pushes come from `bus_push`/`bus_wdata` and pops come from host reads, which load `host_rdata` one cycle later.
  - When `dir_in`=0, pushes come from `host_dma_wr`/`host_wdata` and pops come from `bus_pop`. `bus_rdata` shows the oldest byte combinationally.
  - When `dir_in`=0, host reads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Pulse marking the start of a transfer |
| dma_mode | input | 1 | 1 = DMA transfer, 0 = programmed I/O |
| dir_in | input | 1 | 1 = inbound (bus to host), 0 = outbound |
| tc_nonzero | input | 1 | Remaining transfer count is nonzero |
| bus_push | input | 1 | Bus engine offers a received byte |
| bus_wdata | input | 8 | Byte received from the bus |
| bus_pop | input | 1 | Bus engine takes a byte to send |
| bus_rdata | output | 8 | Oldest byte in the FIFO |
| host_dma_wr | input | 1 | Host DMA write strobe |
| host_wdata | input | 8 | Host DMA write byte |
| host_dma_rd | input | 1 | Host DMA read strobe |
| host_pio_rd | input | 1 | Host data-register read strobe |
| host_rdata | output | 8 | Data register holding the last byte the host popped |
| dreq | output | 1 | DMA request |
| fifo_full | output | 1 | Eight bytes held |
| fifo_empty | output | 1 | No bytes held |

## Verification
The assertions check several properties on every cycle:
- The two flags are never high together.
- A push into a full outbound FIFO keeps it full.
- An inbound read of an empty FIFO leaves the data register and the empty flag unchanged.
- A transfer start in programmed-I/O mode, or with a zero count, leaves the request low.
- An inbound bus byte raises the request.
- Filling or draining in the right direction drops the request.

Only the bench's scenarios can show byte ordering through all eight entries, that a rejected byte is truly absent, the count kept by a simultaneous push and pop, and which end of the FIFO each direction uses.

// File: rtl/xf_pkg.sv
package xf_pkg;
    typedef enum logic [1:0] {
        DQ_OFF  = 2'd0,
        DQ_SEND = 2'd1,
        DQ_RECV = 2'd2
    } dq_state_t;
endpackage

// File: rtl/xf_storage.sv
module xf_storage #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/xf_occupancy.sv
module xf_occupancy #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full_q,
    output logic empty_q,
    output logic next_full,
    output logic next_empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        unique case ({inc, dec})
            2'b10:   cnt_d = cnt_q + CW'(1);
            2'b01:   cnt_d = cnt_q - CW'(1);
            default: cnt_d = cnt_q;
        endcase
    end

    assign next_full  = (cnt_d == CW'(DEPTH));
    assign next_empty = (cnt_d == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_d;
            full_q  <= next_full;
            empty_q <= next_empty;
        end
    end
endmodule

// File: rtl/xf_dreq_ctrl.sv
module xf_dreq_ctrl
    import xf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_start,
    input  logic dma_mode,
    input  logic dir_in,
    input  logic tc_nonzero,
    input  logic full_now,
    input  logic bus_push_acc,
    input  logic dma_rd_acc,
    input  logic next_full,
    input  logic next_empty,
    output logic dreq
);
    dq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (xfer_start) begin
            if (dma_mode && !dir_in && tc_nonzero && !full_now)
                state_d = DQ_SEND;
            else
                state_d = DQ_OFF;
        end else begin
            unique case (state_q)
                DQ_OFF:  if (dma_mode && dir_in && bus_push_acc) state_d = DQ_RECV;
                DQ_SEND: if (next_full) state_d = DQ_OFF;
                DQ_RECV: if (dma_rd_acc && next_empty) state_d = DQ_OFF;
                default: state_d = DQ_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DQ_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            DQ_SEND, DQ_RECV: dreq = 1'b1;
            default:          dreq = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_xfer_fifo.sv
module dma_xfer_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xfer_start,
    input  logic         dma_mode,
    input  logic         dir_in,
    input  logic         tc_nonzero,
    input  logic         bus_push,
    input  logic [W-1:0] bus_wdata,
    input  logic         bus_pop,
    output logic [W-1:0] bus_rdata,
    input  logic         host_dma_wr,
    input  logic [W-1:0] host_wdata,
    input  logic         host_dma_rd,
    input  logic         host_pio_rd,
    output logic [W-1:0] host_rdata,
    output logic         dreq,
    output logic         fifo_full,
    output logic         fifo_empty
);
    logic         push_req, pop_req, push_acc, pop_acc;
    logic         host_pop_acc, dma_rd_acc, bus_push_acc;
    logic         next_full, next_empty;
    logic [W-1:0] push_data, head;
    logic [W-1:0] rdata_q;

    assign push_req  = dir_in ? bus_push : host_dma_wr;
    assign push_data = dir_in ? bus_wdata : host_wdata;
    assign pop_req   = dir_in ? (host_dma_rd | host_pio_rd) : bus_pop;
    assign push_acc  = push_req & ~fifo_full;
    assign pop_acc   = pop_req & ~fifo_empty;

    assign host_pop_acc = dir_in & pop_acc;
    assign dma_rd_acc   = host_pop_acc & host_dma_rd;
    assign bus_push_acc = dir_in & push_acc;

    xf_storage #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_acc),
        .wr_data (push_data),
        .rd_en   (pop_acc),
        .head    (head)
    );

    xf_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (push_acc),
        .dec        (pop_acc),
        .full_q     (fifo_full),
        .empty_q    (fifo_empty),
        .next_full  (next_full),
        .next_empty (next_empty)
    );

    xf_dreq_ctrl u_dreq (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_start   (xfer_start),
        .dma_mode     (dma_mode),
        .dir_in       (dir_in),
        .tc_nonzero   (tc_nonzero),
        .full_now     (fifo_full),
        .bus_push_acc (bus_push_acc),
        .dma_rd_acc   (dma_rd_acc),
        .next_full    (next_full),
        .next_empty   (next_empty),
        .dreq         (dreq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)            rdata_q <= '0;
        else if (host_pop_acc) rdata_q <= head;
    end

    assign host_rdata = rdata_q;
    assign bus_rdata  = head;
endmodule

// File: rtl/xf_checker.sv
module xf_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         xfer_start,
    input logic         dma_mode,
    input logic         dir_in,
    input logic         tc_nonzero,
    input logic         bus_push,
    input logic         bus_pop,
    input logic         host_dma_wr,
    input logic         host_dma_rd,
    input logic         host_pio_rd,
    input logic [W-1:0] host_rdata,
    input logic         dreq,
    input logic         fifo_full,
    input logic         fifo_empty
);
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && !dir_in && host_dma_wr && !bus_pop |=> fifo_full);

    a_r4_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty && dir_in && (host_dma_rd || host_pio_rd) && !bus_push
        |=> $stable(host_rdata) && fifo_empty);

    a_r6_zero_count_low: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start && !tc_nonzero |=> !dreq);

    a_r7_fill_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(xfer_start) && !$past(dir_in) && $rose(fifo_full) |-> !dreq);

    a_r8_arrival_raises: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start && dma_mode && dir_in && bus_push && !fifo_full |=> dreq);

    a_r9_drain_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dir_in) && $past(host_dma_rd) && !$past(xfer_start) && $rose(fifo_empty)
        |-> !dreq);

    a_r10_pio_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start && !dma_mode |=> !dreq);
endmodule

bind dma_xfer_fifo xf_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_start  (xfer_start),
    .dma_mode    (dma_mode),
    .dir_in      (dir_in),
    .tc_nonzero  (tc_nonzero),
    .bus_push    (bus_push),
    .bus_pop     (bus_pop),
    .host_dma_wr (host_dma_wr),
    .host_dma_rd (host_dma_rd),
    .host_pio_rd (host_pio_rd),
    .host_rdata  (host_rdata),
    .dreq        (dreq),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty)
);

// File: tb/test_dma_xfer_fifo.sv
module test_dma_xfer_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_start = 0, dma_mode = 0, dir_in = 0, tc_nonzero = 0;
    logic       bus_push = 0, bus_pop = 0, host_dma_wr = 0, host_dma_rd = 0, host_pio_rd = 0;
    logic [7:0] bus_wdata = 0, host_wdata = 0;
    logic [7:0] bus_rdata, host_rdata;
    logic       dreq, fifo_full, fifo_empty;

    int nchk = 0, nfail = 0, mcnt = 0;
    logic [7:0] exp_q[$];
    logic [7:0] last_rd = 8'h00;
    logic exp_pop = 0, arm = 0;

    always #2 clk = ~clk;

    dma_xfer_fifo i_dma_xfer_fifo (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each accepted host pop against the scoreboard
    always @(posedge clk) arm <= exp_pop;
    always @(negedge clk) begin
        if (arm) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            last_rd = e;
            chk(host_rdata == e, "R11/R2 host pop order", host_rdata, e);
        end
    end

    task automatic clear_strobes();
        xfer_start = 0; bus_push = 0; bus_pop = 0;
        host_dma_wr = 0; host_dma_rd = 0; host_pio_rd = 0; exp_pop = 0;
    endtask

    task automatic start(input bit dm, input bit di, input bit tc);
        @(negedge clk);
        dma_mode = dm; dir_in = di; tc_nonzero = tc; xfer_start = 1;
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic push_in(input logic [7:0] b);
        @(negedge clk);
        bus_push = 1; bus_wdata = b;
        if (mcnt < 8) begin exp_q.push_back(b); mcnt++; end
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic write_out(input logic [7:0] b);
        @(negedge clk);
        host_dma_wr = 1; host_wdata = b;
        if (mcnt < 8) begin exp_q.push_back(b); mcnt++; end
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic host_read(input bit use_dma);
        @(negedge clk);
        host_dma_rd = use_dma; host_pio_rd = !use_dma;
        exp_pop = dir_in && (mcnt > 0);
        if (exp_pop) mcnt--;
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic push_and_read(input logic [7:0] b);
        @(negedge clk);
        bus_push = 1; bus_wdata = b; host_dma_rd = 1;
        exp_pop = (mcnt > 0);
        if (mcnt < 8) exp_q.push_back(b);
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic pop_out();
        logic [7:0] e;
        @(negedge clk);
        bus_pop = 1;
        if (mcnt > 0) begin
            e = exp_q.pop_front();
            mcnt--;
            chk(bus_rdata == e, "R11 bus head order", bus_rdata, e);
        end
        @(negedge clk);
        clear_strobes();
    endtask

    initial begin
        #(4 * 20000);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(fifo_empty == 1, "R1 empty", fifo_empty, 1);
        chk(fifo_full == 0, "R1 full", fifo_full, 0);
        chk(dreq == 0, "R1 dreq", dreq, 0);
        chk(host_rdata == 0, "R1 rdata", host_rdata, 0);

        // inbound DMA
        start(1, 1, 1);
        chk(dreq == 0, "R8 start alone", dreq, 0);
        push_in(8'hA5);
        chk(dreq == 1, "R8 arrival raises", dreq, 1);
        chk(fifo_empty == 0, "R2 not empty", fifo_empty, 0);
        for (int i = 1; i < 8; i++) push_in(8'(8'h10 + i));
        chk(fifo_full == 1, "R2 full after 8", fifo_full, 1);
        push_in(8'hEE);
        chk(fifo_full == 1, "R3 full stays", fifo_full, 1);
        for (int i = 0; i < 7; i++) host_read(1);
        chk(dreq == 1, "R9 dreq while bytes remain", dreq, 1);
        host_read(1);
        @(negedge clk);
        chk(dreq == 0, "R9 drain drops", dreq, 0);
        chk(fifo_empty == 1, "R9 empty", fifo_empty, 1);

        // read while empty
        host_read(0);
        chk(host_rdata == last_rd, "R4 rdata held", host_rdata, last_rd);
        chk(fifo_empty == 1, "R4 still empty", fifo_empty, 1);

        // simultaneous push and pop
        push_in(8'h11);
        push_in(8'h22);
        push_and_read(8'h33);
        chk(fifo_empty == 0 && fifo_full == 0, "R5 count kept", {fifo_full, fifo_empty}, 0);
        host_read(1);
        host_read(1);
        @(negedge clk);
        chk(fifo_empty == 1, "R5 two left then empty", fifo_empty, 1);

        // outbound DMA
        start(1, 0, 0);
        chk(dreq == 0, "R6 zero count", dreq, 0);
        start(1, 0, 1);
        chk(dreq == 1, "R6 outbound raise", dreq, 1);
        for (int i = 0; i < 7; i++) write_out(8'(8'hC0 + i));
        chk(dreq == 1, "R7 dreq before fill", dreq, 1);
        write_out(8'hC7);
        chk(dreq == 0, "R7 fill drops", dreq, 0);
        chk(fifo_full == 1, "R7 full", fifo_full, 1);
        host_read(0);
        chk(host_rdata == last_rd, "R11 outbound host read ignored", host_rdata, last_rd);
        chk(fifo_full == 1, "R11 outbound host read no pop", fifo_full, 1);
        for (int i = 0; i < 8; i++) pop_out();
        chk(fifo_empty == 1, "R2 outbound drained", fifo_empty, 1);

        // programmed I/O start
        start(1, 0, 1);
        chk(dreq == 1, "R10 precondition", dreq, 1);
        start(0, 0, 1);
        chk(dreq == 0, "R10 pio forces low", dreq, 0);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule